// File: doc/BRIEF.md
# Store Queue with Total Store Ordering and Fence Drain

This block sits between a processor core and its data cache and holds the core's stores until the cache takes them. Stores are accepted in program order and written to the cache strictly oldest first, one per handshake. Loads do not wait behind buffered stores:

- A load whose address matches one or more buffered stores is answered in the same cycle, without a cache access. The data comes from the youngest matching store.
- A load with no match goes straight to the cache port, ahead of older stores.

The result is the ordering discipline in which write-to-read order is relaxed and write-to-write order is kept.

A fence request stops the core from issuing further loads and stores until every buffered store has reached the cache. A busy flag tells the core when the fence has finished.

The cache side is one ready/valid request port shared by drain writes and load reads. A read is answered combinationally: the read data is valid in the same cycle as the read handshake.

Top module: `tso_store_queue`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `fence_busy` is 0 and, with no load requested, `mem_valid` is 0.
- R2: A store is taken when `st_valid` and `st_ready` are both 1. `st_ready` is 0 whenever 8 stores are held (the default depth) or a fence is active.
- R3: While stores are held, the queue presents the oldest one on the cache port with `mem_we`=1, unless a load miss wins the port under R6. An entry is removed only when `mem_ready` is 1, so stores reach the cache in acceptance order, at most one per cycle. With nothing held and no load miss, `mem_valid` is 0.
- R4: A load whose address matches no held store is sent to the cache as a read (`mem_valid`=1, `mem_we`=0, `mem_addr`=load address) even while older stores are held. `ld_ready` then equals `mem_ready`, and `ld_data` equals `mem_rdata`.
- R5: A load whose address equals the address of a held store completes in its cycle with `ld_ready`=1 and `ld_fwd`=1. `ld_data` is taken from the youngest matching store, and no cache read is issued.
- R6: When a load miss and a held store compete for the port, the load wins. The exception is a full queue: then the drain write wins and `ld_ready` stays 0.
- R7: A fence is requested by a 1 on `fence_valid`. From that cycle until `fence_busy` falls, both `st_ready` and `ld_ready` are 0, while draining continues.
- R8: `fence_busy` rises the cycle after `fence_valid` and stays 1 until the queue has been empty for one full cycle. It falls on the following edge.
- R9: A load sees only stores accepted in earlier cycles. A store accepted in the same cycle is not forwarded to that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Store accepted this cycle when valid |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| ld_valid | input | 1 | Core offers a load |
| ld_ready | output | 1 | Load completes this cycle |
| ld_addr | input | 32 | Load address |
| ld_data | output | 32 | Load result, valid with ld_ready |
| ld_fwd | output | 1 | Load result came from a held store |
| fence_valid | input | 1 | Fence request pulse |
| fence_busy | output | 1 | Fence in progress |
| mem_valid | output | 1 | Cache request present |
| mem_ready | input | 1 | Cache accepts the request |
| mem_we | output | 1 | 1 = drain write, 0 = load read |
| mem_addr | output | 32 | Cache request address |
| mem_wdata | output | 32 | Drain write data |
| mem_rdata | input | 32 | Read data, valid with a read handshake |

## Verification
The cache port can be claimed in the same cycle by a load miss and by a pending drain write. It can also be used while a new store arrives and an entry leaves, possibly as a fence is being raised.

The bench provokes these collisions in two ways. Directed cycles fill the queue and then issue a miss. A long random sweep over four addresses and random `mem_ready` makes matches, misses and fences overlap freely.

Each cycle is judged against an ordered queue model kept in the bench. The model decides which request must own the port, and what data the load must return, from the held-store count and the youngest match alone.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_LOAD  = 2'd1,
    PORT_DRAIN = 2'd2
  } port_sel_e;
endpackage

// File: rtl/sq_ring.sv
module sq_ring #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] look_addr,
  output logic          look_hit,
  output logic [DW-1:0] look_data,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [IW-1:0] head_q;
  logic [CW-1:0] count_q;

  // physical slot that lies a given number of places after the oldest entry
  function automatic logic [IW-1:0] slot(input logic [IW-1:0] base, input int unsigned off);
    int unsigned s;
    s = (int'(base) + off) % DEPTH;
    return IW'(s);
  endfunction

  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];

  // age-ordered scan: later (younger) matches overwrite earlier ones
  always_comb begin
    look_hit  = 1'b0;
    look_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (CW'(k) < count_q && addr_q[slot(head_q, k)] == look_addr) begin
        look_hit  = 1'b1;
        look_data = data_q[slot(head_q, k)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[slot(head_q, 32'(count_q))] <= push_addr;
      data_q[slot(head_q, 32'(count_q))] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop) head_q <= slot(head_q, 1);
      count_q <= count_q + CW'(push) - CW'(pop);
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) full |-> !push);
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !pop);
endmodule

// File: rtl/sq_port_arb.sv
module sq_port_arb
  import sq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_req,
  input  logic [AW-1:0] ld_addr,
  input  logic          drain_req,
  input  logic          full,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_ready,
  output port_sel_e     sel,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          ld_go,
  output logic          pop
);
  always_comb begin
    if (full && drain_req)  sel = PORT_DRAIN;
    else if (ld_req)        sel = PORT_LOAD;
    else if (drain_req)     sel = PORT_DRAIN;
    else                    sel = PORT_IDLE;
  end

  assign mem_valid = (sel != PORT_IDLE);
  assign mem_we    = (sel == PORT_DRAIN);
  assign mem_addr  = (sel == PORT_LOAD) ? ld_addr : head_addr;
  assign mem_wdata = head_data;
  assign ld_go     = (sel == PORT_LOAD) && mem_ready;
  assign pop       = (sel == PORT_DRAIN) && mem_ready;

  // R6
  drain_first_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && drain_req) |-> (mem_valid && mem_we && !ld_go));
endmodule

// File: rtl/sq_fence_ctl.sv
module sq_fence_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fence_valid,
  input  logic empty,
  output logic busy,
  output logic block
);
  always_ff @(posedge clk) begin
    if (!rst_n)               busy <= 1'b0;
    else if (fence_valid)     busy <= 1'b1;
    else if (busy && empty)   busy <= 1'b0;
  end

  assign block = fence_valid | busy;

  // R8
  fence_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(empty));
  // R8
  fence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !empty) |=> busy);
endmodule

// File: rtl/tso_store_queue.sv
module tso_store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  output logic [DW-1:0] ld_data,
  output logic          ld_fwd,
  input  logic          fence_valid,
  output logic          fence_busy,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  // named internal events
  logic          block, full, empty, look_hit, pop, ld_go, st_fire, ld_miss_req;
  logic [DW-1:0] look_data, head_data;
  logic [AW-1:0] head_addr;
  port_sel_e     sel;

  sq_fence_ctl u_fence (
    .clk(clk), .rst_n(rst_n), .fence_valid(fence_valid), .empty(empty),
    .busy(fence_busy), .block(block)
  );

  assign st_ready    = !block && !full;
  assign st_fire     = st_valid && st_ready;
  assign ld_miss_req = ld_valid && !block && !look_hit;

  sq_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .push(st_fire), .push_addr(st_addr), .push_data(st_data),
    .pop(pop), .look_addr(ld_addr),
    .look_hit(look_hit), .look_data(look_data),
    .head_addr(head_addr), .head_data(head_data),
    .full(full), .empty(empty)
  );

  sq_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .ld_req(ld_miss_req), .ld_addr(ld_addr),
    .drain_req(!empty), .full(full),
    .head_addr(head_addr), .head_data(head_data),
    .mem_ready(mem_ready), .sel(sel),
    .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ld_go(ld_go), .pop(pop)
  );

  assign ld_fwd   = !block && look_hit;
  assign ld_ready = ld_fwd || ld_go;
  assign ld_data  = look_hit ? look_data : mem_rdata;

  // R5
  fwd_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_fwd) |-> !(mem_valid && !mem_we));
  // R4
  miss_uses_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ready && !ld_fwd) |-> (mem_valid && !mem_we && mem_ready && mem_addr == ld_addr));
endmodule

// File: tb/tso_store_queue_test.sv
module tso_store_queue_test;
  localparam int CLK_P = 10;
  localparam int QD    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, ld_valid = 1'b0, fence_valid = 1'b0, mem_ready = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0, ld_addr = '0;
  logic        st_ready, ld_ready, ld_fwd, fence_busy, mem_valid, mem_we;
  logic [31:0] ld_data, mem_addr, mem_wdata, mem_rdata;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    return ~a ^ 32'h1357_9BDF;
  endfunction
  assign mem_rdata = rd_fn(mem_addr);

  tso_store_queue uut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .ld_fwd(ld_fwd), .fence_valid(fence_valid), .fence_busy(fence_busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  typedef struct { logic [31:0] a; logic [31:0] d; } ent_t;
  ent_t q[$];
  int   n_vec = 0, n_bad = 0;
  bit   fb_exp = 1'b0, run = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit sv, input logic [31:0] sa, input logic [31:0] sd,
                     input bit lv, input logic [31:0] la, input bit fv, input bit mr);
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd;
    ld_valid = lv; ld_addr = la; fence_valid = fv; mem_ready = mr;
  endtask

  // model check, one time unit before each rising edge
  always begin
    @(negedge clk);
    #(CLK_P/2 - 1);
    if (rst_n && run) begin
      bit blk, hit, lmiss;
      int sz;
      logic [31:0] hd;
      blk = fence_valid || fb_exp;
      sz  = q.size();
      chk(st_ready == (!blk && sz < QD), "R2/R7 st_ready", 32'(st_ready), 32'(!blk && sz < QD));
      chk(fence_busy == fb_exp, "R8 fence_busy", 32'(fence_busy), 32'(fb_exp));
      // R9: q holds only stores from earlier cycles
      hit = 1'b0; hd = '0;
      for (int k = 0; k < sz; k++) if (q[k].a == ld_addr) begin hit = 1'b1; hd = q[k].d; end
      lmiss = ld_valid && !blk && !hit;
      if (ld_valid) begin
        if (blk) chk(!ld_ready, "R7 load held", 32'(ld_ready), 0);
        else if (hit) begin
          chk(ld_ready && ld_fwd, "R5 fwd ready", {ld_ready, ld_fwd}, 32'd3);
          chk(ld_data == hd, "R5 R9 fwd data", ld_data, hd);
        end else if (sz == QD) chk(!ld_ready, "R6 full drain first", 32'(ld_ready), 0);
        else begin
          chk(mem_valid && !mem_we && mem_addr == ld_addr, "R4 read req", mem_addr, ld_addr);
          chk(ld_ready == mem_ready && !ld_fwd, "R4 ready", 32'(ld_ready), 32'(mem_ready));
          if (mem_ready) chk(ld_data == rd_fn(ld_addr), "R4 data", ld_data, rd_fn(ld_addr));
        end
      end
      if (sz > 0 && !(lmiss && sz < QD)) begin
        chk(mem_valid && mem_we, "R3 R6 drain req", {mem_valid, mem_we}, 32'd3);
        chk(mem_addr == q[0].a && mem_wdata == q[0].d, "R3 drain order", mem_wdata, q[0].d);
      end
      if (sz == 0 && !lmiss) chk(!mem_valid, "R3 idle port", 32'(mem_valid), 0);
      if (fence_valid) fb_exp = 1'b1;
      else if (fb_exp && sz == 0) fb_exp = 1'b0;
      if (mem_valid && mem_we && mem_ready && sz > 0) void'(q.pop_front());
      if (st_valid && st_ready) q.push_back('{a: st_addr, d: st_data});
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(st_ready == 1'b1, "R1 st_ready", 32'(st_ready), 1);
    chk(fence_busy == 1'b0, "R1 fence_busy", 32'(fence_busy), 0);
    chk(mem_valid == 1'b0, "R1 mem_valid", 32'(mem_valid), 0);
    run = 1'b1;
    // R2 fill with duplicated addresses, cache stalled; ninth store refused
    for (int i = 0; i < 9; i++) cyc(1, 32'((i % 3) * 4), 32'h100 + 32'(i), 0, 0, 0, 0);
    // R5 youngest of several matches, R6 miss while full
    cyc(0, 0, 0, 1, 32'd0, 0, 0);
    cyc(0, 0, 0, 1, 32'd4, 0, 0);
    cyc(0, 0, 0, 1, 32'd40, 0, 1);
    // R4 R6 miss passes older stores once not full
    cyc(0, 0, 0, 1, 32'd44, 0, 1);
    cyc(0, 0, 0, 1, 32'd48, 0, 0);
    // R9 store and load to the same fresh address in one cycle
    cyc(1, 32'd60, 32'hABCD, 1, 32'd60, 0, 0);
    cyc(0, 0, 0, 1, 32'd60, 0, 0);
    // R7 R8 fence with slow drain
    cyc(0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 20; i++) cyc(1, 32'd8, 32'(i), 1, 32'd8, 0, i[0]);
    // random sweep
    for (int i = 0; i < 6000; i++) begin
      cyc($urandom_range(0, 2) != 0, 32'($urandom_range(0, 3) * 4), $urandom,
          $urandom_range(0, 1) == 1, 32'($urandom_range(0, 4) * 4),
          $urandom_range(0, 24) == 0, $urandom_range(0, 3) != 0);
    end
    cyc(0, 0, 0, 0, 0, 0, 1);
    repeat (12) cyc(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    run = 1'b0;
    done = 1'b1;
    finish_run();
  end
endmodule